// File: doc/BRIEF.md
# Register Rename Status Table

This block records, for every architectural register of an out-of-order core, which reservation-station tag will produce that register's next value. A dispatch stage presents an instruction here in the same cycle that it reads the register file. The table looks up both source registers and returns a producer tag for each one. A tag of zero means the register file already holds the current value.

In the same issue cycle, the block records the new instruction's reservation-station tag against its destination register. A newer writer always replaces an older one. The block also snoops the result broadcast bus. When a producer completes, the block clears every entry that still names that producer's tag, so later readers take the value from the register file.

A source lookup made in the same cycle as a matching broadcast returns zero, so the reader captures the broadcast value instead of waiting on a tag that will never appear again. The lookup results are registered and appear one cycle after the issue. This matches a register file with a synchronous read.

Top module: `rename_status_table`

## Requirements
- R1: After a synchronous reset, every register's entry is zero, so every source lookup returns tag 0 until a destination write occurs.
- R2: `lookup_valid` is high exactly in the cycle after a cycle with `issue_valid` high, and the source tags shown in that cycle belong to that issue.
- R3: A source lookup returns the tag currently held for the selected register, and 0 when no writer is pending.
- R4: An issue with `issue_dst_en` high writes `issue_tag` (nonzero) into the destination entry, and this replaces any older tag held there.
- R5: A broadcast of nonzero tag T clears every entry equal to T, including several registers at once.
- R6: A broadcast whose tag differs from an entry leaves that entry unchanged. An older producer's completion does not clear a register that a newer issue has renamed.
- R7: When an issue writes a destination in the same cycle as a broadcast, the issue write takes effect, even if the broadcast tag matches that register's old tag or equals the new tag.
- R8: A source lookup made in the same cycle as a broadcast of that register's tag returns 0. A broadcast of a different tag does not alter the lookup.
- R9: Source lookups see the table as it stood before the same cycle's destination write, so an instruction that reads its own destination gets the older producer.
- R10: A destination write does not occur when `issue_dst_en` is low or when `issue_valid` is low.
- R11: With `bcast_valid` low, the value on `bcast_tag` has no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_src_a | input | 5 | First source register index |
| issue_src_b | input | 5 | Second source register index |
| issue_dst | input | 5 | Destination register index |
| issue_dst_en | input | 1 | The instruction writes a destination |
| issue_tag | input | 4 | Reservation-station tag assigned to the instruction (nonzero) |
| bcast_valid | input | 1 | A result is broadcast this cycle |
| bcast_tag | input | 4 | Tag of the completing producer |
| lookup_valid | output | 1 | Source tags below belong to last cycle's issue |
| src_a_tag | output | 4 | Producer tag of the first source, 0 when ready |
| src_b_tag | output | 4 | Producer tag of the second source, 0 when ready |

## Verification
The table is first swept with lookups only, which separates a clean reset from stray writes. Renaming sequences follow: a first write and then an overwrite of the same register, followed by a broadcast of the stale tag. These separate newest-writer-wins from a tag-blind clear. Broadcasts that coincide with an issue cover three cases: the old tag, the reissued tag, and a reader of the completing register. They distinguish write-over-clear priority and read bypass from a design that orders these actions the other way. Issues with the destination disabled, idle cycles that drive destination fields, and broadcasts with the valid bit low each show that the table holds its contents when an enable is low.

// File: rtl/rnt_pkg.sv
package rnt_pkg;
  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_TAG_W    = 4;
endpackage

// File: rtl/rnt_entry.sv
module rnt_entry #(
  parameter int unsigned TAG_W = rnt_pkg::DEF_TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  output logic [TAG_W-1:0] tag
);
  logic clr_hit;
  assign clr_hit = clr_en && (clr_tag != '0) && (tag == clr_tag);

  always_ff @(posedge clk) begin
    if (rst)          tag <= '0;
    else if (wr_en)   tag <= wr_tag;
    else if (clr_hit) tag <= '0;
  end

  // R4 R7
  issue_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tag == $past(wr_tag));

  // R5
  clear_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && clr_en && clr_tag != '0 && tag == clr_tag) |=> tag == '0);

  // R6 R11
  hold_other_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && (!clr_en || tag != clr_tag)) |=> $stable(tag));
endmodule

// File: rtl/rnt_read_port.sv
module rnt_read_port #(
  parameter int unsigned NUM_REGS = rnt_pkg::DEF_NUM_REGS,
  parameter int unsigned TAG_W    = rnt_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  table_q,
  input  logic [IDX_W-1:0]                sel,
  input  logic                            bc_valid,
  input  logic [TAG_W-1:0]                bc_tag,
  output logic [TAG_W-1:0]                tag_q
);
  logic [TAG_W-1:0] picked;
  logic             bypass;

  assign picked = table_q[sel];
  assign bypass = bc_valid && (bc_tag != '0) && (picked == bc_tag);

  always_ff @(posedge clk) begin
    if (rst)         tag_q <= '0;
    else if (bypass) tag_q <= '0;
    else             tag_q <= picked;
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int unsigned NUM_REGS = rnt_pkg::DEF_NUM_REGS,
  parameter int unsigned TAG_W    = rnt_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  input  logic [IDX_W-1:0] issue_src_a,
  input  logic [IDX_W-1:0] issue_src_b,
  input  logic [IDX_W-1:0] issue_dst,
  input  logic             issue_dst_en,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             bcast_valid,
  input  logic [TAG_W-1:0] bcast_tag,
  output logic             lookup_valid,
  output logic [TAG_W-1:0] src_a_tag,
  output logic [TAG_W-1:0] src_b_tag
);
  logic [NUM_REGS-1:0][TAG_W-1:0] table_q;
  logic                           dst_write;

  assign dst_write = issue_valid && issue_dst_en;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    rnt_entry #(.TAG_W(TAG_W)) u_entry (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (dst_write && (issue_dst == IDX_W'(i))),
      .wr_tag  (issue_tag),
      .clr_en  (bcast_valid),
      .clr_tag (bcast_tag),
      .tag     (table_q[i])
    );
  end

  rnt_read_port #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_port_a (
    .clk(clk), .rst(rst), .table_q(table_q), .sel(issue_src_a),
    .bc_valid(bcast_valid), .bc_tag(bcast_tag), .tag_q(src_a_tag)
  );

  rnt_read_port #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_port_b (
    .clk(clk), .rst(rst), .table_q(table_q), .sel(issue_src_b),
    .bc_valid(bcast_valid), .bc_tag(bcast_tag), .tag_q(src_b_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) lookup_valid <= 1'b0;
    else     lookup_valid <= issue_valid;
  end

  // R4
  nonzero_tag_chk: assert property (@(posedge clk) disable iff (rst)
    dst_write |-> issue_tag != '0);

  // R2
  lookup_follow_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> lookup_valid);

  // R2
  lookup_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !lookup_valid);

  // R8
  bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && bcast_valid && bcast_tag != '0) |=> src_a_tag != $past(bcast_tag));

  // R8
  bypass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && bcast_valid && bcast_tag != '0) |=> src_b_tag != $past(bcast_tag));
endmodule

// File: tb/sim_rename_status_table.sv
module sim_rename_status_table;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [4:0] issue_src_a = '0;
  logic [4:0] issue_src_b = '0;
  logic [4:0] issue_dst = '0;
  logic       issue_dst_en = 1'b0;
  logic [3:0] issue_tag = '0;
  logic       bcast_valid = 1'b0;
  logic [3:0] bcast_tag = '0;
  logic       lookup_valid;
  logic [3:0] src_a_tag;
  logic [3:0] src_b_tag;

  int n_checks = 0;
  int n_fails  = 0;
  bit reported = 1'b0;

  logic [3:0] exp_a_q[$];
  logic [3:0] exp_b_q[$];
  string      req_q[$];

  always #2.5 clk = ~clk;

  rename_status_table u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_src_a(issue_src_a),
    .issue_src_b(issue_src_b), .issue_dst(issue_dst), .issue_dst_en(issue_dst_en),
    .issue_tag(issue_tag), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .lookup_valid(lookup_valid), .src_a_tag(src_a_tag), .src_b_tag(src_b_tag)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one issue cycle, with an optional broadcast in the same cycle
  task automatic issue(input int sa, input int sb, input bit den, input int dst,
                       input int tg, input bit bv, input int bt,
                       input int ea, input int eb, input string req);
    @(negedge clk);
    issue_valid  = 1'b1;
    issue_src_a  = 5'(sa);
    issue_src_b  = 5'(sb);
    issue_dst_en = den;
    issue_dst    = 5'(dst);
    issue_tag    = 4'(tg);
    bcast_valid  = bv;
    bcast_tag    = 4'(bt);
    exp_a_q.push_back(4'(ea));
    exp_b_q.push_back(4'(eb));
    req_q.push_back(req);
  endtask

  // Idle cycle: issue_valid low, destination fields and broadcast as given
  task automatic idle(input bit den, input int dst, input int tg, input bit bv, input int bt);
    @(negedge clk);
    issue_valid  = 1'b0;
    issue_dst_en = den;
    issue_dst    = 5'(dst);
    issue_tag    = 4'(tg);
    bcast_valid  = bv;
    bcast_tag    = 4'(bt);
  endtask

  // Monitor: compares each registered lookup against the queued expectation
  always @(negedge clk) begin
    if (!rst && lookup_valid) begin
      if (exp_a_q.size() == 0) begin
        check(1'b0, "R2 unexpected lookup_valid", 1, 0);
      end else begin
        automatic logic [3:0] ea = exp_a_q.pop_front();
        automatic logic [3:0] eb = exp_b_q.pop_front();
        automatic string      rq = req_q.pop_front();
        check(src_a_tag == ea, {rq, " src_a"}, src_a_tag, ea);
        check(src_b_tag == eb, {rq, " src_b"}, src_b_tag, eb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(lookup_valid == 1'b0, "R1 lookup_valid in reset", lookup_valid, 0);
    rst = 1'b0;

    // R1: full sweep, no writes
    for (int i = 0; i < 16; i++) issue(2*i, 2*i+1, 0, 0, 1, 0, 0, 0, 0, "R1 sweep");
    idle(0, 0, 0, 0, 0);
    @(negedge clk);
    check(lookup_valid == 1'b0, "R2 idle lookup_valid", lookup_valid, 0);

    // R9: the instruction reads its own destination and sees the older state
    issue(5, 6, 1, 5, 3, 0, 0, 0, 0, "R9 own dest");
    // R3 R4: the new mapping is visible
    issue(5, 6, 0, 0, 1, 0, 0, 3, 0, "R3 R4 mapped");
    // R4: WAW overwrite
    issue(5, 5, 1, 5, 7, 0, 0, 3, 3, "R9 before overwrite");
    idle(0, 0, 0, 1, 3);
    // R6: the stale producer's broadcast leaves the newer tag
    issue(5, 6, 0, 0, 1, 0, 0, 7, 0, "R6 WAW survives");
    idle(0, 0, 0, 1, 7);
    issue(5, 6, 0, 0, 1, 0, 0, 0, 0, "R5 cleared");

    // R5: several entries cleared at once
    issue(0, 0, 1, 10, 4, 0, 0, 0, 0, "R5 setup");
    issue(0, 0, 1, 11, 4, 0, 0, 0, 0, "R5 setup");
    issue(10, 11, 0, 0, 1, 0, 0, 4, 4, "R5 both set");
    idle(0, 0, 0, 1, 4);
    issue(10, 11, 0, 0, 1, 0, 0, 0, 0, "R5 both cleared");

    // R7: issue write wins over a same-cycle clear
    issue(0, 0, 1, 12, 5, 0, 0, 0, 0, "R7 setup");
    issue(0, 0, 1, 12, 6, 1, 5, 0, 0, "R7 old tag bcast");
    issue(0, 0, 1, 13, 8, 0, 0, 0, 0, "R7 setup");
    issue(12, 13, 1, 14, 8, 1, 8, 6, 0, "R7 R8 reissue tag");
    issue(13, 14, 0, 0, 1, 0, 0, 0, 8, "R7 reissued kept");

    // R8: read bypass during a matching broadcast, none for another tag
    issue(14, 12, 0, 0, 1, 1, 8, 0, 6, "R8 bypass");
    issue(14, 12, 0, 0, 1, 1, 9, 0, 6, "R8 no bypass");

    // R10: destination disabled, or no issue
    issue(12, 0, 0, 12, 2, 0, 0, 6, 0, "R10 dst_en low");
    idle(1, 12, 2, 0, 0);
    issue(12, 0, 0, 0, 1, 0, 0, 6, 0, "R10 after idle write");

    // R11: broadcast with valid low
    idle(0, 0, 0, 0, 6);
    issue(12, 12, 0, 0, 1, 0, 6, 6, 6, "R11 invalid bcast");

    idle(0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    check(exp_a_q.size() == 0, "R2 lookups outstanding", exp_a_q.size(), 0);
    report();
  end
endmodule